// File: doc/BRIEF.md
# Pixel Row Gate-Signal Sequencer

This block generates the five per-row control levels of an eight-transistor, one-capacitor emissive pixel: the emission enable and four scan lines (S1 to S4). Time is measured in horizontal-line periods, marked by a one-cycle `h_tick` strobe. A `frame_start` pulse begins a frame, and a mode flag sampled with it selects a full refresh frame or a skip frame.

A refresh frame runs the whole programming sequence. Emission goes off, then the anode and source are reset on S4. The driver gate is initialised on S2 alone. The driver drain is initialised on S1 with S2. Data is sampled on S1 with S3. A final source reset on S4 follows, and then emission resumes. A skip frame leaves the oxide-switch lines S1 and S2 and the sampling line S3 idle. It only turns emission off, applies one source reset on S4 and turns emission back on. The skip reset width is programmed separately from the refresh reset width (typical values are 12 H for refresh and about 40 H for skip), so the driver transistor's hysteresis can offset the luminance drift that builds up across skipped frames.

Every programmed phase width is a count of H periods. A one-H idle gap separates adjacent phases so that conflicting switches never overlap.

Top module: `gseq_row_sequencer`

## Requirements
- R1: After synchronous reset, and until the first `frame_start`, all five outputs are low and `h_tick` has no effect.
- R2: A `frame_start` takes priority over everything else, including an `h_tick` in the same cycle. On the following cycle all outputs are low, and the sequence restarts from its first step whatever phase it was in.
- R3: With `frame_refresh`=1, the outputs as {em,s1,s2,s3,s4} follow this order: 00001 for `anode_init_w` H, 00100 for `gate_init_w` H, 01100 for `drain_init_w` H, 01010 for 1 H, 00001 for `reset_refresh_w` H, then 10000.
- R4: Each run of the sequence starts with one H of all-low (emission off), and exactly one all-low H lies between consecutive active phases and before emission turns on.
- R5: With `frame_refresh`=0, the outputs are: one all-low H, 00001 for `reset_skip_w` H, one all-low H, then 10000. S1, S2 and S3 stay low for the whole skip frame.
- R6: The final S4 reset uses `reset_refresh_w` in a refresh frame and `reset_skip_w` in a skip frame, and the other width has no effect.
- R7: S3 is high for exactly one H, and only together with S1 and with S2 and S4 low.
- R8: Emission, once on, stays on until the next `frame_start` and is never high together with any scan line.
- R9: A programmed width of 0 acts as a width of 1 H.
- R10: The widths and the mode are captured at `frame_start`. Changing them later in the frame does not change the frame in progress.
- R11: Outputs change only on a clock edge where `h_tick` or `frame_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle frame begin pulse |
| frame_refresh | input | 1 | 1 = refresh frame, 0 = skip frame; sampled with frame_start |
| h_tick | input | 1 | One-cycle pulse per horizontal-line period |
| anode_init_w | input | CNT_W | Width in H of the first S4 phase (refresh) |
| gate_init_w | input | CNT_W | Width in H of the S2-only phase |
| drain_init_w | input | CNT_W | Width in H of the S1+S2 phase |
| reset_refresh_w | input | CNT_W | Width in H of the final S4 phase in a refresh frame |
| reset_skip_w | input | CNT_W | Width in H of the S4 phase in a skip frame |
| em_on | output | 1 | Emission enable |
| s1_on | output | 1 | Scan line S1 active |
| s2_on | output | 1 | Scan line S2 active |
| s3_on | output | 1 | Scan line S3 active |
| s4_on | output | 1 | Scan line S4 active |

## Verification
The hardest case to reach is a new frame start that lands inside a phase with a partly counted width. The worst form of this has the start and an `h_tick` in the same cycle, or changes the mode relative to the aborted frame. Random frames draw sparse `h_tick` patterns and abort at a random cycle, so restarts land in every phase at every count. A directed case forces the start-plus-tick collision. The width inputs are re-randomised on every cycle after a frame starts, which shows that only the captured values shape the frame in progress.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_LEAD,
    PH_ANODE,
    PH_GAP1,
    PH_GATE,
    PH_GAP2,
    PH_DRAIN,
    PH_GAP3,
    PH_SAMPLE,
    PH_GAP4,
    PH_RESET,
    PH_GAP5,
    PH_EMIT
  } phase_e;

  typedef struct packed {
    logic em;
    logic s1;
    logic s2;
    logic s3;
    logic s4;
  } lines_t;

endpackage

// File: rtl/gseq_h_timer.sv
module gseq_h_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] dur,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  // a zero width is treated as one H
  always_comb begin
    last = (dur == '0) ? '0 : dur - 1'b1;
    done = tick && !clear && (cnt_q >= last);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (done) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gseq_dur_sel.sv
module gseq_dur_sel
  import gseq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  phase_e           phase,
  input  logic             is_skip,
  input  logic [CNT_W-1:0] anode_w,
  input  logic [CNT_W-1:0] gate_w,
  input  logic [CNT_W-1:0] drain_w,
  input  logic [CNT_W-1:0] rst_ref_w,
  input  logic [CNT_W-1:0] rst_skip_w,
  output logic [CNT_W-1:0] dur
);
  localparam logic [CNT_W-1:0] ONE_H = CNT_W'(1);

  always_comb begin
    unique case (phase)
      PH_ANODE: dur = anode_w;
      PH_GATE:  dur = gate_w;
      PH_DRAIN: dur = drain_w;
      PH_RESET: dur = is_skip ? rst_skip_w : rst_ref_w;
      default:  dur = ONE_H;
    endcase
  end
endmodule

// File: rtl/gseq_phase_ctrl.sv
module gseq_phase_ctrl
  import gseq_pkg::*;
(
  input  phase_e phase_q,
  input  logic   is_skip,
  input  logic   frame_start,
  input  logic   done,
  output phase_e phase_d
);
  always_comb begin
    phase_d = phase_q;
    if (frame_start) begin
      phase_d = PH_LEAD;
    end else if (done) begin
      unique case (phase_q)
        PH_LEAD:   phase_d = is_skip ? PH_RESET : PH_ANODE;
        PH_ANODE:  phase_d = PH_GAP1;
        PH_GAP1:   phase_d = PH_GATE;
        PH_GATE:   phase_d = PH_GAP2;
        PH_GAP2:   phase_d = PH_DRAIN;
        PH_DRAIN:  phase_d = PH_GAP3;
        PH_GAP3:   phase_d = PH_SAMPLE;
        PH_SAMPLE: phase_d = PH_GAP4;
        PH_GAP4:   phase_d = PH_RESET;
        PH_RESET:  phase_d = PH_GAP5;
        PH_GAP5:   phase_d = PH_EMIT;
        default:   phase_d = phase_q;
      endcase
    end
  end
endmodule

// File: rtl/gseq_line_decode.sv
module gseq_line_decode
  import gseq_pkg::*;
(
  input  phase_e phase,
  output lines_t lines
);
  always_comb begin
    lines = '0;
    unique case (phase)
      PH_ANODE:  lines.s4 = 1'b1;
      PH_GATE:   lines.s2 = 1'b1;
      PH_DRAIN:  begin lines.s1 = 1'b1; lines.s2 = 1'b1; end
      PH_SAMPLE: begin lines.s1 = 1'b1; lines.s3 = 1'b1; end
      PH_RESET:  lines.s4 = 1'b1;
      PH_EMIT:   lines.em = 1'b1;
      default:   lines = '0;
    endcase
  end
endmodule

// File: rtl/gseq_row_sequencer.sv
module gseq_row_sequencer
  import gseq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             frame_refresh,
  input  logic             h_tick,
  input  logic [CNT_W-1:0] anode_init_w,
  input  logic [CNT_W-1:0] gate_init_w,
  input  logic [CNT_W-1:0] drain_init_w,
  input  logic [CNT_W-1:0] reset_refresh_w,
  input  logic [CNT_W-1:0] reset_skip_w,
  output logic             em_on,
  output logic             s1_on,
  output logic             s2_on,
  output logic             s3_on,
  output logic             s4_on
);
  phase_e           phase_q, phase_d;
  logic             skip_q;
  logic [CNT_W-1:0] anode_q, gate_q, drain_q, rref_q, rskip_q;
  logic [CNT_W-1:0] dur;
  logic             done;
  lines_t           lines_d;

  // widths and mode captured once per frame
  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q  <= 1'b0;
      anode_q <= '0;
      gate_q  <= '0;
      drain_q <= '0;
      rref_q  <= '0;
      rskip_q <= '0;
    end else if (frame_start) begin
      skip_q  <= !frame_refresh;
      anode_q <= anode_init_w;
      gate_q  <= gate_init_w;
      drain_q <= drain_init_w;
      rref_q  <= reset_refresh_w;
      rskip_q <= reset_skip_w;
    end
  end

  gseq_dur_sel #(.CNT_W(CNT_W)) dur_i (
    .phase      (phase_q),
    .is_skip    (skip_q),
    .anode_w    (anode_q),
    .gate_w     (gate_q),
    .drain_w    (drain_q),
    .rst_ref_w  (rref_q),
    .rst_skip_w (rskip_q),
    .dur        (dur)
  );

  gseq_h_timer #(.CNT_W(CNT_W)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .clear (frame_start),
    .tick  (h_tick),
    .dur   (dur),
    .done  (done)
  );

  gseq_phase_ctrl ctrl_i (
    .phase_q     (phase_q),
    .is_skip     (skip_q),
    .frame_start (frame_start),
    .done        (done),
    .phase_d     (phase_d)
  );

  gseq_line_decode dec_i (
    .phase (phase_d),
    .lines (lines_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      em_on   <= 1'b0;
      s1_on   <= 1'b0;
      s2_on   <= 1'b0;
      s3_on   <= 1'b0;
      s4_on   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      em_on   <= lines_d.em;
      s1_on   <= lines_d.s1;
      s2_on   <= lines_d.s2;
      s3_on   <= lines_d.s3;
      s4_on   <= lines_d.s4;
    end
  end
endmodule

// File: rtl/gseq_row_sequencer_chk.sv
module gseq_row_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic frame_refresh,
  input logic h_tick,
  input logic em_on,
  input logic s1_on,
  input logic s2_on,
  input logic s3_on,
  input logic s4_on
);
  logic skip_mode_q;

  always_ff @(posedge clk) begin
    if (rst) skip_mode_q <= 1'b0;
    else if (frame_start) skip_mode_q <= !frame_refresh;
  end

  p_start_blank_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !(em_on || s1_on || s2_on || s3_on || s4_on));

  p_em_alone_r8: assert property (@(posedge clk) disable iff (rst)
    em_on |-> !(s1_on || s2_on || s3_on || s4_on));

  p_sample_pair_r7: assert property (@(posedge clk) disable iff (rst)
    s3_on |-> (s1_on && !s2_on && !s4_on));

  p_sample_one_h_r7: assert property (@(posedge clk) disable iff (rst)
    (s3_on && h_tick && !frame_start) |=> !s3_on);

  p_skip_idle_r5: assert property (@(posedge clk) disable iff (rst)
    skip_mode_q |-> !(s1_on || s2_on || s3_on));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !h_tick) |=>
      $stable({em_on, s1_on, s2_on, s3_on, s4_on}));

  p_em_gap_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(em_on) |-> $past(!(s1_on || s2_on || s3_on || s4_on)));
endmodule

bind gseq_row_sequencer gseq_row_sequencer_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .frame_start   (frame_start),
  .frame_refresh (frame_refresh),
  .h_tick        (h_tick),
  .em_on         (em_on),
  .s1_on         (s1_on),
  .s2_on         (s2_on),
  .s3_on         (s3_on),
  .s4_on         (s4_on)
);

// File: tb/gseq_row_sequencer_tb.sv
`timescale 1ns/1ps
module gseq_row_sequencer_tb_top;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic frame_refresh = 1'b1;
  logic h_tick = 1'b0;
  logic [CNT_W-1:0] anode_init_w = '0, gate_init_w = '0, drain_init_w = '0;
  logic [CNT_W-1:0] reset_refresh_w = '0, reset_skip_w = '0;
  logic em_on, s1_on, s2_on, s3_on, s4_on;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit started = 0;
  bit m_skip = 0;
  int k = 0;
  int la, lg, ld, lrr, lrs;

  always #2.5 clk = ~clk;

  gseq_row_sequencer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .frame_refresh(frame_refresh), .h_tick(h_tick),
    .anode_init_w(anode_init_w), .gate_init_w(gate_init_w),
    .drain_init_w(drain_init_w), .reset_refresh_w(reset_refresh_w),
    .reset_skip_w(reset_skip_w), .em_on(em_on), .s1_on(s1_on),
    .s2_on(s2_on), .s3_on(s3_on), .s4_on(s4_on)
  );

  function automatic int cl(int w);
    return (w == 0) ? 1 : w;
  endfunction

  // expected {em,s1,s2,s3,s4} after k H ticks since the frame start
  function automatic logic [4:0] exp_lines(bit skip, int kk, int wa, int wg,
                                           int wd, int wrr, int wrs);
    int p;
    if (kk < 1) return 5'b00000;
    p = 1;
    if (skip) begin
      if (kk < p + cl(wrs)) return 5'b00001;
      p += cl(wrs);
      if (kk < p + 1) return 5'b00000;
      return 5'b10000;
    end
    if (kk < p + cl(wa)) return 5'b00001;
    p += cl(wa);
    if (kk < p + 1) return 5'b00000;
    p += 1;
    if (kk < p + cl(wg)) return 5'b00100;
    p += cl(wg);
    if (kk < p + 1) return 5'b00000;
    p += 1;
    if (kk < p + cl(wd)) return 5'b01100;
    p += cl(wd);
    if (kk < p + 1) return 5'b00000;
    p += 1;
    if (kk < p + 1) return 5'b01010;
    p += 1;
    if (kk < p + 1) return 5'b00000;
    p += 1;
    if (kk < p + cl(wrr)) return 5'b00001;
    p += cl(wrr);
    if (kk < p + 1) return 5'b00000;
    return 5'b10000;
  endfunction

  task automatic check(input string tag);
    logic [4:0] exp, act;
    exp = started ? exp_lines(m_skip, k, la, lg, ld, lrr, lrs) : 5'b00000;
    act = {em_on, s1_on, s2_on, s3_on, s4_on};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s k=%0d skip=%0d actual=%b expected=%b",
               tag, k, m_skip, act, exp);
    end
  endtask

  // called at a negedge: drive, take one edge, update the model, check
  task automatic step(input bit fs, input bit ht, input string tag);
    frame_start = fs;
    h_tick = ht;
    @(posedge clk);
    if (fs) begin
      started = 1;
      k = 0;
      m_skip = !frame_refresh;
      la = anode_init_w; lg = gate_init_w; ld = drain_init_w;
      lrr = reset_refresh_w; lrs = reset_skip_w;
    end else if (ht && started) begin
      k++;
    end
    @(negedge clk);
    frame_start = 0;
    h_tick = 0;
    check(tag);
  endtask

  task automatic set_w(input int a, input int g, input int d,
                       input int rr, input int rs);
    anode_init_w = CNT_W'(a); gate_init_w = CNT_W'(g);
    drain_init_w = CNT_W'(d); reset_refresh_w = CNT_W'(rr);
    reset_skip_w = CNT_W'(rs);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    int n;
    seed = 1234;
    void'($urandom(seed));
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst = 0;
    // R1: ticks before any frame start do nothing
    for (int i = 0; i < 4; i++) step(0, 1, "R1 no frame yet");

    // R3 R4 R7 R8: refresh frame, tick every cycle
    set_w(2, 3, 2, 12, 40);
    frame_refresh = 1;
    step(1, 0, "R3 start");
    for (int i = 0; i < 30; i++) step(0, 1, "R3 R4 R7 R8 refresh");

    // R5 R6: skip frame uses the skip reset width
    frame_refresh = 0;
    step(1, 0, "R5 start");
    for (int i = 0; i < 50; i++) step(0, 1, "R5 R6 skip");

    // R6: refresh frame ignores the skip width
    set_w(1, 1, 1, 5, 60);
    frame_refresh = 1;
    step(1, 0, "R6 start");
    for (int i = 0; i < 16; i++) step(0, 1, "R6 refresh width");

    // R9: zero widths act as one H
    set_w(0, 0, 0, 0, 0);
    step(1, 0, "R9 start");
    for (int i = 0; i < 14; i++) step(0, 1, "R9 zero width");
    frame_refresh = 0;
    step(1, 0, "R9 skip start");
    for (int i = 0; i < 5; i++) step(0, 1, "R9 zero skip width");

    // R2: abort mid-phase with a tick in the same cycle, mode changes
    set_w(4, 4, 4, 6, 8);
    frame_refresh = 1;
    step(1, 0, "R2 start");
    for (int i = 0; i < 7; i++) step(0, 1, "R2 before abort");
    frame_refresh = 0;
    step(1, 1, "R2 abort with tick");
    for (int i = 0; i < 12; i++) step(0, 1, "R2 after abort");

    // R10: inputs change after capture; R11: sparse ticks
    frame_refresh = 1;
    set_w(3, 2, 2, 4, 9);
    step(1, 0, "R10 start");
    for (int i = 0; i < 60; i++) begin
      set_w($urandom_range(0, 20), $urandom_range(0, 20), $urandom_range(0, 20),
            $urandom_range(0, 20), $urandom_range(0, 20));
      frame_refresh = $urandom_range(0, 1);
      step(0, (i % 3) == 0, "R10 R11 held config");
    end

    // random frames with random aborts
    for (int f = 0; f < 60; f++) begin
      set_w($urandom_range(0, 10), $urandom_range(0, 10), $urandom_range(0, 10),
            $urandom_range(0, 16), $urandom_range(0, 50));
      frame_refresh = $urandom_range(0, 1);
      step(1, $urandom_range(0, 1), "R2 R3 R5 random start");
      n = $urandom_range(5, 120);
      for (int i = 0; i < n; i++) begin
        set_w($urandom_range(0, 10), $urandom_range(0, 10), $urandom_range(0, 10),
              $urandom_range(0, 16), $urandom_range(0, 50));
        step(0, $urandom_range(0, 2) != 0, "R3 R5 R10 R11 random");
      end
    end
    finish_run();
  end
endmodule